// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns word-wide register accesses into byte cycles on an 8-bit asynchronous NAND flash bus. A write to the command register runs one bus cycle with the command latch line high. A write to the address register runs one with the address latch line high. A data-register write drives one data byte, and a data-register read samples one byte. Every cycle goes through four timed phases: setup, strobe width, hold and a ready-wait gap. Each phase length comes from a packed timing register, and read cycles and write cycles have their own fields.

The register port has a valid/ready handshake. It stalls any new access while a bus cycle is in flight. A read returns its data on a one-cycle response strobe. Software drives chip enable through a configuration bit. The device ready/busy pin is synchronised and shown in a status word. A rising ready edge latches an interrupt flag, and the expiry of a programmable data-byte count latches a second flag. Both flags are masked by an enable register and cleared by writing ones. A self-clearing soft-reset bit returns every register to its reset value.

Top module: `nand_seq`

## Requirements
- R1: A write to word address 1 (command) runs one bus cycle. During its low-strobe phase nand_cle is 1, nand_ale is 0, nand_dq_out equals req_wdata[7:0] and nand_dq_oe is 1.
- R2: A write to word address 2 (address) runs one bus cycle. During its low-strobe phase nand_ale is 1, nand_cle is 0 and nand_dq_out equals req_wdata[7:0]. A write to word address 0 (data) drives the byte with both latch lines low.
- R3: The timing word at address 9 holds eight 4-bit clock counts. From bits 3:0 upward they are: read setup, read hold, read width, read ready-wait, write setup, write hold, write width, write ready-wait. In a write cycle nand_we_n is low for exactly the write-width count. nand_dq_oe is high for setup + width + hold clocks, and the setup clocks come before the strobe falls. req_ready stays low for setup + width + hold + ready-wait + 1 clocks after the accepting edge.
- R4: A read of word address 0 runs a read cycle. In it nand_re_n is low for the read-width count, nand_we_n stays high and nand_dq_oe stays 0. The byte on nand_dq_in at the last clock of the width phase is returned as rsp_data[7:0], with the upper bits zero. rsp_valid is 1 in the first clock in which req_ready is high again.
- R5: A timing field of 0 acts as one clock, so with an all-zero timing word a cycle holds req_ready low for 5 clocks.
- R6: While a bus cycle is in progress, req_ready is 0 and no new access is taken.
- R7: Bit 5 of the configuration word (address 4) drives nand_ce_n low while it is set and high while it is clear. The configuration word reads back with that bit.
- R8: Bit 0 of the status word (address 5) follows nand_rdy after synchronisation. Bit 0 of the interrupt status (address 6) sets on a rising ready edge. Writing 1 to bit 0 of the clear register (address 8) clears it. irq is the OR of the interrupt status bits ANDed with the enable register (address 7, bits 1:0).
- R9: Each completed data-register bus cycle decrements a nonzero byte count (address 10). The decrement that reaches 0 sets interrupt status bit 1.
- R10: A write with bit 2 set to the control register (address 3) returns configuration, timing, enables, status flags and count to 0. The control word always reads 0.
- R11: After reset nand_we_n, nand_re_n and nand_ce_n are 1, nand_cle, nand_ale, nand_dq_oe, irq and rsp_valid are 0, req_ready is 1, and register reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register word address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Access accepted when high with req_valid |
| rsp_valid | output | 1 | Read data valid strobe |
| rsp_data | output | 32 | Read data |
| irq | output | 1 | Masked interrupt request |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_dq_out | output | 8 | Bus byte driven to the device |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 8 | Bus byte from the device |
| nand_rdy | input | 1 | Device ready/busy pin |

## Verification
The bench sets random timing words that include zero nibbles and measures strobe width, drive window, setup lead and stall length against sums it computes from the fields. A design that did not stretch zero counts would return ready one or more clocks early, and one that swapped the nibble order would stretch the wrong phase. Read cycles change the bus byte once the read strobe has risen, so a design that sampled after the width phase returns the changed value. The bench also drives the count down to zero, clears the ready flag while the enable gates irq, and issues a soft reset after loading every register; a missed clear or a flag set one cycle late shows up in the read-back values.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_WIDTH,
        PH_HOLD,
        PH_WAIT
    } phase_e;

    typedef enum logic [1:0] {
        CY_CMD,
        CY_ADDR,
        CY_WDATA,
        CY_RDATA
    } cyc_e;

    localparam int unsigned REG_AW   = 4;
    localparam int unsigned REG_DW   = 32;
    localparam int unsigned BUS_W    = 8;
    localparam int unsigned NFIELDS  = 8;
    localparam int unsigned NIRQ     = 2;

    localparam logic [REG_AW-1:0] RA_DATA  = 4'd0;
    localparam logic [REG_AW-1:0] RA_CMD   = 4'd1;
    localparam logic [REG_AW-1:0] RA_ADDR  = 4'd2;
    localparam logic [REG_AW-1:0] RA_CTRL  = 4'd3;
    localparam logic [REG_AW-1:0] RA_CFG   = 4'd4;
    localparam logic [REG_AW-1:0] RA_STAT  = 4'd5;
    localparam logic [REG_AW-1:0] RA_ISTAT = 4'd6;
    localparam logic [REG_AW-1:0] RA_IEN   = 4'd7;
    localparam logic [REG_AW-1:0] RA_ICLR  = 4'd8;
    localparam logic [REG_AW-1:0] RA_TIME  = 4'd9;
    localparam logic [REG_AW-1:0] RA_COUNT = 4'd10;

    localparam int unsigned CE_BIT   = 5;
    localparam int unsigned SRST_BIT = 2;

    // field index order inside the timing word, lowest nibble first
    localparam int unsigned FI_SETUP = 0;
    localparam int unsigned FI_HOLD  = 1;
    localparam int unsigned FI_WIDTH = 2;
    localparam int unsigned FI_READY = 3;
    localparam int unsigned FI_WBASE = 4;

endpackage

// File: rtl/nseq_rdy_sync.sv
module nseq_rdy_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o
);
    localparam int unsigned CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    generate
        for (genvar g = 0; g < CHAIN; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/nseq_timer.sv
module nseq_timer
    import nseq_pkg::*;
#(
    parameter int unsigned FW = 4,
    parameter int unsigned BW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  cyc_e              kind_i,
    input  logic [BW-1:0]     wbyte_i,
    input  logic [NFIELDS*FW-1:0] timing_i,
    input  logic [BW-1:0]     dq_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [BW-1:0]     rbyte_o,
    output logic              cle_o,
    output logic              ale_o,
    output logic              we_n_o,
    output logic              re_n_o,
    output logic [BW-1:0]     dq_o,
    output logic              dq_oe_o
);
    typedef struct packed {
        phase_e        phase;
        logic [FW-1:0] cnt;
        cyc_e          kind;
        logic [BW-1:0] byte_v;
        logic          done;
    } tstate_t;

    tstate_t st_d, st_q;

    // phase length minus one; a zero field still lasts one clock
    function automatic logic [FW-1:0] load_of(input logic rd, input int unsigned fidx);
        logic [FW-1:0] f;
        int unsigned   base;
        base = rd ? 0 : FI_WBASE;
        f    = timing_i[(base + fidx)*FW +: FW];
        return (f == '0) ? '0 : f - 1'b1;
    endfunction

    logic is_rd;
    logic active;

    assign is_rd  = (st_q.kind == CY_RDATA);
    assign active = (st_q.phase == PH_SETUP) || (st_q.phase == PH_WIDTH) ||
                    (st_q.phase == PH_HOLD);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase  = PH_SETUP;
                    st_d.kind   = kind_i;
                    st_d.byte_v = wbyte_i;
                    st_d.cnt    = load_of(kind_i == CY_RDATA, FI_SETUP);
                end
            end
            PH_SETUP: begin
                if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
                else begin
                    st_d.phase = PH_WIDTH;
                    st_d.cnt   = load_of(is_rd, FI_WIDTH);
                end
            end
            PH_WIDTH: begin
                if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
                else begin
                    st_d.phase = PH_HOLD;
                    st_d.cnt   = load_of(is_rd, FI_HOLD);
                    if (is_rd) st_d.byte_v = dq_i;
                end
            end
            PH_HOLD: begin
                if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
                else begin
                    st_d.phase = PH_WAIT;
                    st_d.cnt   = load_of(is_rd, FI_READY);
                end
            end
            PH_WAIT: begin
                if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
                else begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, kind: CY_CMD, byte_v: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o  = (st_q.phase != PH_IDLE);
    assign done_o  = st_q.done;
    assign rbyte_o = st_q.byte_v;
    assign cle_o   = active && (st_q.kind == CY_CMD);
    assign ale_o   = active && (st_q.kind == CY_ADDR);
    assign we_n_o  = !((st_q.phase == PH_WIDTH) && !is_rd);
    assign re_n_o  = !((st_q.phase == PH_WIDTH) && is_rd);
    assign dq_o    = st_q.byte_v;
    assign dq_oe_o = active && !is_rd;

    // R1
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle_o && ale_o));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n_o && !re_n_o));

    // R3
    width_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_WIDTH && st_q.cnt != '0) |=> (st_q.phase == PH_WIDTH));

endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nseq_pkg::*;
#(
    parameter int unsigned FIELD_W     = 4,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [3:0]  req_addr,
    input  logic [31:0] req_wdata,
    output logic        req_ready,
    output logic        rsp_valid,
    output logic [31:0] rsp_data,
    output logic        irq,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic        nand_ce_n,
    output logic [7:0]  nand_dq_out,
    output logic        nand_dq_oe,
    input  logic [7:0]  nand_dq_in,
    input  logic        nand_rdy
);
    localparam int unsigned TW = NFIELDS * FIELD_W;

    typedef struct packed {
        logic              cfg_ce;
        logic [TW-1:0]     timing;
        logic [NIRQ-1:0]   ien;
        logic [NIRQ-1:0]   ist;
        logic [CNT_W-1:0]  tcount;
        logic              pend;
        logic              pend_rd;
        logic              pend_dat;
        logic              rsp_valid;
        logic [REG_DW-1:0] rsp_data;
    } rstate_t;

    localparam rstate_t RST_Q = '{
        cfg_ce: 1'b0, timing: '0, ien: '0, ist: '0, tcount: '0,
        pend: 1'b0, pend_rd: 1'b0, pend_dat: 1'b0,
        rsp_valid: 1'b0, rsp_data: '0
    };

    rstate_t rs_d, rs_q;

    logic             rdy_lvl, rdy_rise;
    logic             tm_start, tm_busy, tm_done;
    cyc_e             tm_kind;
    logic [BUS_W-1:0] tm_rbyte;
    logic             acc;
    logic             wr_acc;
    logic [NIRQ-1:0]  clr_mask;

    nseq_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (nand_rdy),
        .level_o (rdy_lvl),
        .rise_o  (rdy_rise)
    );

    nseq_timer #(.FW(FIELD_W), .BW(BUS_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (tm_start),
        .kind_i   (tm_kind),
        .wbyte_i  (req_wdata[BUS_W-1:0]),
        .timing_i (rs_q.timing),
        .dq_i     (nand_dq_in),
        .busy_o   (tm_busy),
        .done_o   (tm_done),
        .rbyte_o  (tm_rbyte),
        .cle_o    (nand_cle),
        .ale_o    (nand_ale),
        .we_n_o   (nand_we_n),
        .re_n_o   (nand_re_n),
        .dq_o     (nand_dq_out),
        .dq_oe_o  (nand_dq_oe)
    );

    assign acc    = req_valid && !rs_q.pend;
    assign wr_acc = acc && req_write;
    assign clr_mask = (wr_acc && req_addr == RA_ICLR) ? req_wdata[NIRQ-1:0] : '0;

    always_comb begin
        rs_d           = rs_q;
        rs_d.rsp_valid = 1'b0;
        tm_start       = 1'b0;
        tm_kind        = CY_CMD;

        // flag clear first so a same-cycle set wins
        rs_d.ist = rs_q.ist & ~clr_mask;
        if (rdy_rise) rs_d.ist[0] = 1'b1;

        if (tm_done) begin
            rs_d.pend     = 1'b0;
            rs_d.pend_rd  = 1'b0;
            rs_d.pend_dat = 1'b0;
            if (rs_q.pend_rd) begin
                rs_d.rsp_valid = 1'b1;
                rs_d.rsp_data  = {{(REG_DW-BUS_W){1'b0}}, tm_rbyte};
            end
            if (rs_q.pend_dat && rs_q.tcount != '0) begin
                rs_d.tcount = rs_q.tcount - 1'b1;
                if (rs_q.tcount == CNT_W'(1)) rs_d.ist[1] = 1'b1;
            end
        end

        if (acc) begin
            if (req_write) begin
                case (req_addr)
                    RA_DATA: begin
                        tm_start      = 1'b1;
                        tm_kind       = CY_WDATA;
                        rs_d.pend     = 1'b1;
                        rs_d.pend_dat = 1'b1;
                    end
                    RA_CMD: begin
                        tm_start  = 1'b1;
                        tm_kind   = CY_CMD;
                        rs_d.pend = 1'b1;
                    end
                    RA_ADDR: begin
                        tm_start  = 1'b1;
                        tm_kind   = CY_ADDR;
                        rs_d.pend = 1'b1;
                    end
                    RA_CTRL:  if (req_wdata[SRST_BIT]) rs_d = RST_Q;
                    RA_CFG:   rs_d.cfg_ce = req_wdata[CE_BIT];
                    RA_IEN:   rs_d.ien    = req_wdata[NIRQ-1:0];
                    RA_TIME:  rs_d.timing = req_wdata[TW-1:0];
                    RA_COUNT: rs_d.tcount = req_wdata[CNT_W-1:0];
                    default: ;
                endcase
            end else begin
                if (req_addr == RA_DATA) begin
                    tm_start      = 1'b1;
                    tm_kind       = CY_RDATA;
                    rs_d.pend     = 1'b1;
                    rs_d.pend_rd  = 1'b1;
                    rs_d.pend_dat = 1'b1;
                end else begin
                    rs_d.rsp_valid = 1'b1;
                    case (req_addr)
                        RA_CFG:   rs_d.rsp_data = REG_DW'(rs_q.cfg_ce) << CE_BIT;
                        RA_STAT:  rs_d.rsp_data = REG_DW'(rdy_lvl);
                        RA_ISTAT: rs_d.rsp_data = REG_DW'(rs_q.ist);
                        RA_IEN:   rs_d.rsp_data = REG_DW'(rs_q.ien);
                        RA_TIME:  rs_d.rsp_data = REG_DW'(rs_q.timing);
                        RA_COUNT: rs_d.rsp_data = REG_DW'(rs_q.tcount);
                        default:  rs_d.rsp_data = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= RST_Q;
        else        rs_q <= rs_d;
    end

    assign req_ready = !rs_q.pend;
    assign rsp_valid = rs_q.rsp_valid;
    assign rsp_data  = rs_q.rsp_data;
    assign irq       = |(rs_q.ist & rs_q.ien);
    assign nand_ce_n = !rs_q.cfg_ce;

    // R6
    stall_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tm_busy |-> !req_ready);

    // R8
    rdy_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_rise && !(wr_acc && req_addr == RA_CTRL)) |=> rs_q.ist[0]);

    // R7
    ce_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_acc && (req_addr == RA_CFG || req_addr == RA_CTRL)) |=> $stable(nand_ce_n));

    // R4
    rsp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(tm_done) || $past(acc && !req_write)));

endmodule

// File: tb/nand_seq_bench.sv
module nand_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, irq;
    logic [31:0] rsp_data;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_ce_n, nand_dq_oe;
    logic [7:0]  nand_dq_out;
    logic [7:0]  nand_dq_in = '0;
    logic        nand_rdy = 1'b0;

    int nchk = 0;
    int nfail = 0;
    logic [31:0] tv = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_seq u_nand_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq(irq),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_ce_n(nand_ce_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rdy(nand_rdy)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int fld(input logic [31:0] t, input int idx);
        int v;
        v = int'(t[idx*4 +: 4]);
        return (v == 0) ? 1 : v;
    endfunction

    // idx: 0 setup, 1 hold, 2 width, 3 ready-wait
    function automatic int ph(input logic [31:0] t, input bit rd, input int idx);
        return fld(t, (rd ? 0 : 4) + idx);
    endfunction

    task automatic issue(input logic w, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
        issue(1'b1, a, d);
        if (a == 4'd9) tv = d;
        if (a == 4'd3 && d[2]) tv = '0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
        issue(1'b0, a, 32'h0);
        @(negedge clk);
        d = rsp_valid ? rsp_data : 32'hDEAD_BEEF;
    endtask

    // kind: 0 data, 1 command, 2 address
    task automatic bus_write(input logic [3:0] a, input logic [7:0] b, input string req);
        int n, wl, oe, sc;
        bit sig_ok, seen_low;
        n = 0; wl = 0; oe = 0; sc = 0; sig_ok = 1; seen_low = 0;
        issue(1'b1, a, {24'h5A5A5A, b});
        forever begin
            @(negedge clk);
            if (req_ready) break;
            n++;
            if (!nand_re_n) sig_ok = 0;
            if (nand_dq_oe) oe++;
            if (nand_dq_oe && nand_we_n && !seen_low) sc++;
            if (!nand_we_n) begin
                seen_low = 1;
                wl++;
                if (nand_dq_out != b || !nand_dq_oe) sig_ok = 0;
                if (nand_cle != (a == 4'd1) || nand_ale != (a == 4'd2)) sig_ok = 0;
            end
        end
        chk(sig_ok, {req, " lines/byte"}, {nand_cle, nand_ale, nand_dq_out}, {8'h0, b});
        chk(wl == ph(tv, 0, 2), "R3 write width", wl, ph(tv, 0, 2));
        chk(sc == ph(tv, 0, 0), "R3 write setup", sc, ph(tv, 0, 0));
        chk(oe == ph(tv, 0, 0) + ph(tv, 0, 1) + ph(tv, 0, 2), "R3 drive window",
            oe, ph(tv, 0, 0) + ph(tv, 0, 1) + ph(tv, 0, 2));
        chk(n == ph(tv, 0, 0) + ph(tv, 0, 1) + ph(tv, 0, 2) + ph(tv, 0, 3) + 1,
            "R6 stall length", n,
            ph(tv, 0, 0) + ph(tv, 0, 1) + ph(tv, 0, 2) + ph(tv, 0, 3) + 1);
    endtask

    task automatic bus_read(input logic [7:0] b);
        int n, rl;
        bit ok, seen, changed;
        n = 0; rl = 0; ok = 1; seen = 0; changed = 0;
        nand_dq_in = b;
        issue(1'b0, 4'd0, 32'h0);
        forever begin
            @(negedge clk);
            if (req_ready) break;
            n++;
            if (nand_dq_oe || !nand_we_n || nand_cle || nand_ale) ok = 0;
            if (!nand_re_n) begin seen = 1; rl++; end
            else if (seen && !changed) begin changed = 1; nand_dq_in = ~b; end
        end
        chk(ok, "R4 read lines quiet", {nand_dq_oe, nand_we_n}, 32'h1);
        chk(rl == ph(tv, 1, 2), "R4 read width", rl, ph(tv, 1, 2));
        chk(rsp_valid && rsp_data == {24'h0, b}, "R4 read data", rsp_data, {24'h0, b});
        chk(n == ph(tv, 1, 0) + ph(tv, 1, 1) + ph(tv, 1, 2) + ph(tv, 1, 3) + 1,
            "R6 read stall", n,
            ph(tv, 1, 0) + ph(tv, 1, 1) + ph(tv, 1, 2) + ph(tv, 1, 3) + 1);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(nand_we_n && nand_re_n && nand_ce_n && !nand_cle && !nand_ale && !nand_dq_oe
            && !irq && !rsp_valid && req_ready, "R11 idle pins",
            {nand_we_n, nand_re_n, nand_ce_n, nand_cle, nand_ale, nand_dq_oe, irq, req_ready},
            32'hE1);
        reg_rd(4'd9, d);  chk(d == 0, "R11 timing reads 0", d, 0);
        reg_rd(4'd6, d);  chk(d == 0, "R11 flags read 0", d, 0);

        // R5 all-zero timing: every phase one clock
        bus_write(4'd1, 8'hA5, "R1 command");
        bus_write(4'd2, 8'h3C, "R2 address");
        bus_read(8'h96);

        // R3 directed: distinct nibbles
        reg_wr(4'd9, 32'h3152_2413);
        reg_rd(4'd9, d); chk(d == 32'h3152_2413, "R3 timing readback", d, 32'h3152_2413);
        bus_write(4'd0, 8'h11, "R2 data");
        bus_read(8'hC3);
        reg_wr(4'd9, 32'hFFFF_FFFF);
        bus_write(4'd1, 8'hFF, "R1 command max");
        bus_read(8'h01);

        // random mix
        for (int i = 0; i < 20; i++) begin
            int k;
            logic [7:0] b;
            reg_wr(4'd9, $urandom);
            k = int'($urandom % 4);
            b = 8'($urandom);
            case (k)
                0: bus_write(4'd0, b, "R2 data");
                1: bus_write(4'd1, b, "R1 command");
                2: bus_write(4'd2, b, "R2 address");
                default: bus_read(b);
            endcase
        end
        reg_wr(4'd9, 32'h0);

        // R7 chip enable
        reg_wr(4'd4, 32'h20);
        @(negedge clk);
        chk(nand_ce_n == 0, "R7 ce low", nand_ce_n, 0);
        reg_rd(4'd4, d); chk(d == 32'h20, "R7 cfg readback", d, 32'h20);
        reg_wr(4'd4, 32'h0);
        @(negedge clk);
        chk(nand_ce_n == 1, "R7 ce high", nand_ce_n, 1);

        // R8 ready pin and flag
        reg_rd(4'd5, d); chk(d == 0, "R8 status busy", d, 0);
        nand_rdy = 1'b1;
        repeat (4) @(negedge clk);
        reg_rd(4'd5, d); chk(d == 1, "R8 status ready", d, 1);
        reg_rd(4'd6, d); chk(d[0] == 1, "R8 flag set", d, 1);
        chk(irq == 0, "R8 irq masked", irq, 0);
        reg_wr(4'd7, 32'h1);
        @(negedge clk);
        chk(irq == 1, "R8 irq enabled", irq, 1);
        reg_wr(4'd8, 32'h1);
        @(negedge clk);
        chk(irq == 0, "R8 irq after clear", irq, 0);
        reg_rd(4'd6, d); chk(d == 0, "R8 flag cleared", d, 0);

        // R9 byte count
        reg_wr(4'd10, 32'd3);
        bus_write(4'd0, 8'h21, "R2 data");
        bus_read(8'h22);
        reg_rd(4'd6, d); chk(d[1] == 0, "R9 not yet done", d, 0);
        reg_rd(4'd10, d); chk(d == 1, "R9 count left", d, 1);
        bus_write(4'd1, 8'h90, "R1 command");
        reg_rd(4'd10, d); chk(d == 1, "R9 command not counted", d, 1);
        bus_write(4'd0, 8'h23, "R2 data");
        reg_rd(4'd6, d); chk(d[1] == 1, "R9 done flag", d, 2);

        // R10 soft reset
        reg_wr(4'd4, 32'h20);
        reg_wr(4'd9, 32'h1234_5678);
        reg_wr(4'd7, 32'h3);
        reg_wr(4'd10, 32'd9);
        reg_wr(4'd3, 32'h4);
        @(negedge clk);
        chk(nand_ce_n == 1 && irq == 0, "R10 pins after soft reset", {nand_ce_n, irq}, 2);
        reg_rd(4'd9, d);  chk(d == 0, "R10 timing cleared", d, 0);
        reg_rd(4'd7, d);  chk(d == 0, "R10 enable cleared", d, 0);
        reg_rd(4'd10, d); chk(d == 0, "R10 count cleared", d, 0);
        reg_rd(4'd6, d);  chk(d == 0, "R10 flags cleared", d, 0);
        reg_rd(4'd3, d);  chk(d == 0, "R10 ctrl reads 0", d, 0);
        bus_write(4'd2, 8'h5E, "R2 address after reset");

        summary();
    end

endmodule